// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block sits beside a small 8-bit microcontroller core and decides when the core is held in reset and which clock domains run. It watches a raw reset pin, a write strobe into the power-control register, and a pending-interrupt flag. From these it produces a qualified core reset, a CPU clock enable, a peripheral clock enable, an oscillator-run enable and a signal that forces the I/O port latches high.

A machine cycle is twelve oscillator clocks, marked by a free-running divider that advances only while the oscillator is enabled. The reset pin is synchronised and must stay high for two full machine cycles before the core reset asserts. The port latches are forced high at once, without waiting for that qualification. The core reset is released on the first machine-cycle boundary after the pin falls. Writing the idle bit stops only the CPU clock, and any pending interrupt restarts it. Writing the power-down bit stops the oscillator, and only a qualified hardware reset brings the core back.

The register port is a plain one-cycle write strobe with no back-pressure. A write is taken on the clock edge where the strobe is high, the CPU clock is enabled and the core reset is low; otherwise it is dropped. All outputs are plain control levels.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: With the pin held high, `core_rst` rises on the 26th oscillator edge after the pin rises (a two-stage synchroniser plus 24 clocks, which is two 12-clock machine cycles). A high pulse shorter than 24 clocks, or two such pulses split by a single low clock, never asserts it.
- R2: `io_force_hi` is high in the same instant the pin is high, with no clock edge needed, and stays high while `core_rst` is high.
- R3: Register layout: bit 0 idle, bit 1 power-down, bit 2 general flag 0, bit 3 general flag 1, bit 7 baud-double flag. Bits 6..4 always read 0, and a qualified reset clears the whole register to 0x00.
- R4: A write with both bit 1 and bit 0 set stores power-down and leaves idle clear.
- R5: After an idle write, from the next edge on, `cpu_clk_en` is 0 while `per_clk_en` and `osc_run` stay 1.
- R6: After a power-down write, `cpu_clk_en`, `per_clk_en` and `osc_run` are all 0 while the pin stays low. A high pin raises `osc_run` again two edges later.
- R7: In power-down, interrupts and register writes change nothing. Only a qualified reset clears bit 1.
- R8: In idle, a pending interrupt clears bit 0 at the next edge and restores `cpu_clk_en` while the flag bits are kept. Outside idle, an interrupt has no effect on the register.
- R9: Writes are ignored while `core_rst` is high or the CPU clock is disabled.
- R10: `core_rst` falls between 3 and 14 edges after the pin falls, always on the same phase of the count of oscillator-enabled clocks modulo 12.
- R11: A qualified reset taken during idle ends idle and clears the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw asynchronous reset pin, active high |
| reg_wr_en | input | 1 | One-cycle write strobe for the power-control register |
| reg_wr_data | input | 8 | Write data for the power-control register |
| irq_pend | input | 1 | An enabled interrupt is pending |
| core_rst | output | 1 | Qualified core reset, active high |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral, RAM-interface and interrupt clock enable |
| osc_run | output | 1 | Oscillator run enable |
| io_force_hi | output | 1 | Forces the port latches to logic 1 |
| ctrl_reg | output | 8 | Current power-control register value |

## Verification
A qualification counter that is off by one moves the rising edge of `core_rst` by exactly one clock relative to the pin. A divider that is wrong shifts the release phase modulo 12 or pushes it outside the 3 to 14 edge window, and that shows on the very next reset. Errors in the mode state appear on the clock enables and on `ctrl_reg` at the first edge after the write or interrupt that should have moved it. A power-down state that leaks shows up as `osc_run` or a register bit changing while the pin stays low.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  // Field positions are decoded by the CPU, so they are fixed.
  localparam int unsigned BIT_IDLE  = 0;
  localparam int unsigned BIT_PDOWN = 1;
  localparam int unsigned BIT_GF0   = 2;
  localparam int unsigned BIT_GF1   = 3;
  localparam int unsigned BIT_DBL   = 7;

  localparam logic [7:0] IMPL_MASK = 8'h8F;

  typedef struct packed {
    logic       dbl;
    logic [2:0] rsvd;
    logic       gf1;
    logic       gf0;
    logic       pdown;
    logic       idle;
  } pctl_t;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pmode_e;

endpackage

// File: rtl/pr_sync.sv
module pr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain = '0;

  generate
    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pr_mc_div.sv
module pr_mc_div #(
  parameter int unsigned MC_CLKS = 12
) (
  input  logic clk,
  input  logic run,
  output logic tick
);
  localparam int unsigned W = (MC_CLKS > 1) ? $clog2(MC_CLKS) : 1;
  localparam logic [W-1:0] LAST = W'(MC_CLKS - 1);

  logic [W-1:0] phase = '0;

  assign tick = run && (phase == LAST);

  always_ff @(posedge clk) begin
    if (run) begin
      if (phase == LAST) phase <= '0;
      else               phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/pr_qualifier.sv
module pr_qualifier #(
  parameter int unsigned HOLD_CLKS = 24
) (
  input  logic clk,
  input  logic pin_s,
  input  logic mc_tick,
  output logic core_rst
);
  localparam int unsigned CW = $clog2(HOLD_CLKS + 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CLKS - 1);

  logic [CW-1:0] held = '0;
  logic          rst_q = 1'b1;

  always_ff @(posedge clk) begin
    if (!pin_s) begin
      held <= '0;
      if (rst_q && mc_tick) rst_q <= 1'b0;
    end else if (held == FULL) begin
      rst_q <= 1'b1;
    end else begin
      held <= held + 1'b1;
    end
  end

  assign core_rst = rst_q;
endmodule

// File: rtl/pr_mode_reg.sv
module pr_mode_reg
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       core_rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       irq_pend,
  output pctl_t      ctrl_q,
  output pmode_e     mode
);
  pctl_t cur = '0;
  pctl_t nxt;

  always_comb begin
    nxt = cur;
    if (cur.pdown) begin
      nxt = cur;
    end else if (cur.idle) begin
      if (irq_pend) nxt.idle = 1'b0;
    end else if (wr_en) begin
      nxt       = pctl_t'(wr_data & IMPL_MASK);
      nxt.idle  = wr_data[BIT_IDLE] & ~wr_data[BIT_PDOWN];
    end
  end

  always_ff @(posedge clk) begin
    if (core_rst) cur <= '0;
    else          cur <= nxt;
  end

  always_comb begin
    if (cur.pdown)     mode = MODE_PDOWN;
    else if (cur.idle) mode = MODE_IDLE;
    else               mode = MODE_RUN;
  end

  assign ctrl_q = cur;
endmodule

// File: rtl/pwr_rst_ctrl.sv
module pwr_rst_ctrl
  import pwr_pkg::*;
#(
  parameter int unsigned MC_CLKS     = 12,
  parameter int unsigned QUAL_MCS    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_pin,
  input  logic       reg_wr_en,
  input  logic [7:0] reg_wr_data,
  input  logic       irq_pend,
  output logic       core_rst,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_run,
  output logic       io_force_hi,
  output logic [7:0] ctrl_reg
);
  localparam int unsigned HOLD_CLKS = MC_CLKS * QUAL_MCS;

  logic   pin_s;
  logic   mc_tick;
  pctl_t  ctrl_q;
  pmode_e mode;

  pr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (rst_pin),
    .q   (pin_s)
  );

  // Oscillator stays stopped in power-down until the pin wakes it.
  assign osc_run = (mode != MODE_PDOWN) || pin_s;

  pr_mc_div #(.MC_CLKS(MC_CLKS)) u_div (
    .clk  (clk),
    .run  (osc_run),
    .tick (mc_tick)
  );

  pr_qualifier #(.HOLD_CLKS(HOLD_CLKS)) u_qual (
    .clk      (clk),
    .pin_s    (pin_s),
    .mc_tick  (mc_tick),
    .core_rst (core_rst)
  );

  pr_mode_reg u_mode (
    .clk      (clk),
    .core_rst (core_rst),
    .wr_en    (reg_wr_en),
    .wr_data  (reg_wr_data),
    .irq_pend (irq_pend),
    .ctrl_q   (ctrl_q),
    .mode     (mode)
  );

  assign cpu_clk_en  = osc_run && (mode == MODE_RUN);
  assign per_clk_en  = osc_run && (mode != MODE_PDOWN);
  assign io_force_hi = rst_pin || core_rst;
  assign ctrl_reg    = ctrl_q;
endmodule

// File: rtl/pwr_rst_ctrl_chk.sv
module pwr_rst_ctrl_chk (
  input logic       clk,
  input logic       rst_pin,
  input logic       reg_wr_en,
  input logic [7:0] reg_wr_data,
  input logic       irq_pend,
  input logic       core_rst,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       osc_run,
  input logic       io_force_hi,
  input logic [7:0] ctrl_reg
);
  // R2: latches forced high with no clock involved
  always_comb begin
    if (rst_pin) a_r2_force_now: assert (io_force_hi);
  end

  // R3: unimplemented bits read zero
  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (core_rst)
    ctrl_reg[6:4] == 3'b000);

  // R4: power-down wins over idle in one write
  a_r4_pd_priority: assert property (@(posedge clk) disable iff (core_rst)
    $past(!core_rst && reg_wr_en && cpu_clk_en && reg_wr_data[1])
      |-> (ctrl_reg[1] && !ctrl_reg[0]));

  // R5: idle gates the CPU only
  a_r5_idle_cpu_only: assert property (@(posedge clk) disable iff (core_rst)
    ctrl_reg[0] |-> (!cpu_clk_en && per_clk_en && osc_run));

  // R6: power-down with a quiet pin stops everything
  a_r6_pd_all_off: assert property (@(posedge clk) disable iff (core_rst)
    (ctrl_reg[1] && !rst_pin && !$past(rst_pin) && !$past(rst_pin, 2))
      |-> (!osc_run && !per_clk_en && !cpu_clk_en));

  // R7: nothing but reset leaves power-down
  a_r7_pd_sticky: assert property (@(posedge clk) disable iff (core_rst)
    $past(ctrl_reg[1]) |-> ctrl_reg[1]);

  // R8: interrupt wakes the CPU from idle
  a_r8_irq_wake: assert property (@(posedge clk) disable iff (core_rst)
    $past(!core_rst && ctrl_reg[0] && irq_pend) |-> cpu_clk_en);
endmodule

bind pwr_rst_ctrl pwr_rst_ctrl_chk u_chk (
  .clk         (clk),
  .rst_pin     (rst_pin),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .irq_pend    (irq_pend),
  .core_rst    (core_rst),
  .cpu_clk_en  (cpu_clk_en),
  .per_clk_en  (per_clk_en),
  .osc_run     (osc_run),
  .io_force_hi (io_force_hi),
  .ctrl_reg    (ctrl_reg)
);

// File: tb/pwr_rst_ctrl_test.sv
module pwr_rst_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_pin = 1'b1;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic       irq_pend = 1'b0;
  logic       core_rst, cpu_clk_en, per_clk_en, osc_run, io_force_hi;
  logic [7:0] ctrl_reg;

  int checks = 0;
  int fails = 0;
  int oscc = 0;
  int phase_ref = -1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_rst_ctrl uut (
    .clk(clk), .rst_pin(rst_pin), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .irq_pend(irq_pend), .core_rst(core_rst),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_run(osc_run),
    .io_force_hi(io_force_hi), .ctrl_reg(ctrl_reg)
  );

  function automatic logic [7:0] next_reg(logic [7:0] r, logic wr, logic [7:0] d, logic irq);
    logic [7:0] n = r;
    if (r[1]) n = r;
    else if (r[0]) begin if (irq) n[0] = 1'b0; end
    else if (wr) begin n = d & 8'h8F; if (d[1]) n[0] = 1'b0; end
    return n;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic o = osc_run;
    @(posedge clk);
    @(negedge clk);
    if (o) oscc++;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write(logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_data = d;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic release_pin(string req);
    int n = 0;
    rst_pin = 1'b0;
    while (core_rst && n < 30) begin tick(); n++; end
    chk({req, " release window"}, 8'((n >= 3 && n <= 14) ? 1 : 0), 8'd1);
    if (phase_ref < 0) phase_ref = oscc % 12;
    else chk({req, " release phase"}, 8'(oscc % 12), 8'(phase_ref));
  endtask

  task automatic qualify();
    rst_pin = 1'b1;
    ticks(30);
  endtask

  initial begin : main
    logic [7:0] exp;
    logic wr, irq;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    #1;
    chk("R2 force at time zero", 8'(io_force_hi), 8'd1);
    @(negedge clk);
    ticks(40);
    chk("R3 reset state reg", ctrl_reg, 8'h00);
    chk("R3 reset core_rst", 8'(core_rst), 8'd1);
    chk("R2 force held in reset", 8'(io_force_hi), 8'd1);
    release_pin("R10");
    chk("R10 force low after release", 8'(io_force_hi), 8'd0);

    // R1 exact qualification latency
    rst_pin = 1'b1;
    #1 chk("R2 immediate force", 8'(io_force_hi), 8'd1);
    ticks(25);
    chk("R1 not yet at 25", 8'(core_rst), 8'd0);
    tick();
    chk("R1 asserted at 26", 8'(core_rst), 8'd1);
    ticks(5);
    release_pin("R10 second");

    // R1 short pulses and restart
    rst_pin = 1'b1; ticks(20); rst_pin = 1'b0; tick();
    rst_pin = 1'b1; ticks(20); rst_pin = 1'b0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (core_rst) begin chk("R1 short pulse", 8'(core_rst), 8'd0); break; end
    end
    chk("R1 no reset from split pulses", 8'(core_rst), 8'd0);

    // R3 layout, R4 priority, R6, R7
    write(8'h70);
    chk("R3 unimplemented bits", ctrl_reg, 8'h00);
    write(8'hFF);
    chk("R4 pd priority", ctrl_reg, 8'h8E);
    chk("R6 osc off", 8'(osc_run), 8'd0);
    chk("R6 per off", 8'(per_clk_en), 8'd0);
    chk("R6 cpu off", 8'(cpu_clk_en), 8'd0);
    irq_pend = 1'b1; tick(); irq_pend = 1'b0;
    chk("R7 irq ignored in pd", ctrl_reg, 8'h8E);
    write(8'h00);
    chk("R7 write ignored in pd", ctrl_reg, 8'h8E);
    rst_pin = 1'b1;
    tick();
    chk("R6 osc still off one edge", 8'(osc_run), 8'd0);
    tick();
    chk("R6 osc wakes from pin", 8'(osc_run), 8'd1);
    ticks(26);
    chk("R7 reset clears pd", ctrl_reg, 8'h00);
    release_pin("R10 after pd");

    // R5, R9, R8
    write(8'h05);
    chk("R5 idle reg", ctrl_reg, 8'h05);
    chk("R5 cpu gated", 8'(cpu_clk_en), 8'd0);
    chk("R5 per runs", 8'(per_clk_en), 8'd1);
    chk("R5 osc runs", 8'(osc_run), 8'd1);
    write(8'h80);
    chk("R9 write ignored in idle", ctrl_reg, 8'h05);
    irq_pend = 1'b1; tick(); irq_pend = 1'b0;
    chk("R8 irq clears idle", ctrl_reg, 8'h04);
    chk("R8 cpu restored", 8'(cpu_clk_en), 8'd1);
    irq_pend = 1'b1; tick(); irq_pend = 1'b0;
    chk("R8 irq outside idle", ctrl_reg, 8'h04);

    // R11 reset ends idle
    write(8'h89);
    chk("R11 idle set", ctrl_reg, 8'h89);
    qualify();
    chk("R11 reset clears idle", ctrl_reg, 8'h00);
    chk("R11 cpu enabled in reset", 8'(cpu_clk_en), 8'd1);
    write(8'h8C);
    chk("R9 write ignored in reset", ctrl_reg, 8'h00);
    release_pin("R10 after idle");

    // Random traffic without power-down
    exp = ctrl_reg;
    for (int k = 0; k < 600; k++) begin
      wr  = ($urandom % 3) == 0;
      irq = ($urandom % 4) == 0;
      d   = 8'($urandom) & 8'hFD;
      reg_wr_en = wr; reg_wr_data = d; irq_pend = irq;
      tick();
      exp = next_reg(exp, wr, d, irq);
      chk("R8/R9 random reg", ctrl_reg, exp);
      chk("R5 random cpu", 8'(cpu_clk_en), 8'(!exp[0] && !exp[1]));
      chk("R5 random per", 8'(per_clk_en), 8'd1);
    end
    reg_wr_en = 1'b0; irq_pend = 1'b0;

    qualify();
    release_pin("R10 final");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule